// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a serial peripheral master with one chip select, placed behind a simple 32-bit register bus. Software sets the word length and the serial clock rate in a configuration register. It asserts the chip select through a control bit and starts a transfer by writing a word to the transmit register. The block then shifts that word out on MOSI and takes the slave's word in from MISO at the same time. When the last bit is done, a cause flag goes high and the received word can be read from the receive register.

The serial clock is the system clock divided by an even value from 4 to 30. The prescaler field holds a marker bit in bit 4 and half the divisor in bits [3:0]. A field without the marker bit, or with a half-divisor below 2, runs at the fastest rate, which is a divisor of 4. Only clock mode 0 is supported. The clock idles low, the slave's bit is sampled on each rising edge and the next MOSI bit is driven after each falling edge, most significant bit first. Before each word, software clears the cause flag by writing zero to it.

Top module: `spim_ctrl`

## Requirements
- R1: Registers are decoded at byte offsets 0x00 control, 0x04 configuration, 0x08 transmit, 0x0C receive and 0x10 cause. Reads of the transmit register and of any unmapped offset return 0. Reads are combinational while bus_en is high.
- R2: Control bit 0 drives the chip select, with 1 meaning asserted (spi_csn low). The bit reads back at bit 0. After reset the chip select is deasserted.
- R3: Configuration bit 5 selects the word length: 0 gives 8 bits and 1 gives 16 bits. In 8-bit mode the word is taken from bits [7:0] of the transmit write, and the receive register returns the word in bits [7:0] with zeros above. In 16-bit mode both registers use bits [15:0].
- R4: With a valid prescaler field P (bit 4 set, P[3:0] ≥ 2) the serial clock period is 2·P[3:0] system cycles. The cause flag becomes readable exactly 2·N·P[3:0] cycles after the clock edge that accepts the transmit write, where N is the word length.
- R5: A prescaler field with bit 4 clear, or with P[3:0] below 2, behaves as a divisor of 4 (half-divisor 2).
- R6: A transmit write starts a transfer. When it finishes, the cause register reads 1. Writing 0 to the cause register clears it. A nonzero write leaves it unchanged.
- R7: Once the cause flag is set, the receive register holds the word shifted in from MISO during that transfer.
- R8: Clock mode 0: spi_sclk and spi_mosi are low when idle. MOSI carries the word MSB first, each bit valid before the rising edge on which the slave samples it. MISO is sampled on rising edges.
- R9: A transmit write while a transfer is in progress is ignored. The running word, its timing and its result are unchanged.
- R10: Configuration bit 14 is stored and reads back. It has no effect on the shifting or its timing. Configuration reads return bits 14, 5 and [4:0] and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_csn | output | 1 | Chip select, active low |

## Verification
The bench builds the block with its default address width of 5 bits, so the unmapped offset 0x14 is reachable for the read-as-zero check. With this build it can drive prescaler fields for divisors 4, 6 and 30, and fields with no marker bit or a half-divisor of 1 that must fall back to a divisor of 4. It also covers both word lengths, upper transmit bits that must be dropped in 8-bit mode, a second transmit write during a running transfer, and the inert timing bit. A slave model in the bench captures MOSI on rising edges and changes MISO on falling edges. It also counts cycles from the accepted write to the cause flag.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BUS_W    = 32;
    localparam int WORD_MAX = 16;
    localparam int WORD_MIN = 8;
    localparam int HALF_W   = 4;
    localparam int CNT_W    = $clog2(WORD_MAX);
    localparam int PRE_W    = 5;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CFG   = 'h04;
    localparam int OFF_TX    = 'h08;
    localparam int OFF_RX    = 'h0C;
    localparam int OFF_CAUSE = 'h10;

    localparam int CFG_WIDE_BIT  = 5;
    localparam int CFG_TWEAK_BIT = 14;

    typedef struct packed {
        logic             tweak;
        logic             wide;
        logic [PRE_W-1:0] presc;
    } cfg_t;

    // Half-period length in system cycles; bad fields fall back to 2.
    function automatic logic [HALF_W-1:0] eff_half(input logic [PRE_W-1:0] f);
        if (!f[PRE_W-1] || f[HALF_W-1:0] < HALF_W'(2))
            return HALF_W'(2);
        return f[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                done,
    input  logic [WORD_MAX-1:0] rx_word,
    output logic                cs_on,
    output cfg_t                cfg,
    output logic                tx_wr,
    output logic [WORD_MAX-1:0] tx_word
);

    logic wr;
    logic sel_ctrl, sel_cfg, sel_tx, sel_rx, sel_cause;
    logic cause_q;
    logic [WORD_MAX-1:0] rx_q;

    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_cfg   = (bus_addr == ADDR_W'(OFF_CFG));
        sel_tx    = (bus_addr == ADDR_W'(OFF_TX));
        sel_rx    = (bus_addr == ADDR_W'(OFF_RX));
        sel_cause = (bus_addr == ADDR_W'(OFF_CAUSE));
        wr        = bus_en & bus_we;
        tx_wr     = wr & sel_tx;
        tx_word   = bus_wdata[WORD_MAX-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_on   <= 1'b0;
            cfg     <= '0;
            cause_q <= 1'b0;
            rx_q    <= '0;
        end else begin
            if (wr && sel_ctrl)
                cs_on <= bus_wdata[0];
            if (wr && sel_cfg) begin
                cfg.tweak <= bus_wdata[CFG_TWEAK_BIT];
                cfg.wide  <= bus_wdata[CFG_WIDE_BIT];
                cfg.presc <= bus_wdata[PRE_W-1:0];
            end
            if (done) begin
                cause_q <= 1'b1;
                rx_q    <= rx_word;
            end else if (wr && sel_cause && bus_wdata == '0) begin
                cause_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (sel_ctrl)
                bus_rdata[0] = cs_on;
            else if (sel_cfg) begin
                bus_rdata[CFG_TWEAK_BIT] = cfg.tweak;
                bus_rdata[CFG_WIDE_BIT]  = cfg.wide;
                bus_rdata[PRE_W-1:0]     = cfg.presc;
            end else if (sel_rx)
                bus_rdata[WORD_MAX-1:0] = rx_q;
            else if (sel_cause)
                bus_rdata[0] = cause_q;
        end
    end

    // R6: completion raises the flag on the next cycle
    a_r6_done_sets_cause: assert property (@(posedge clk) disable iff (rst)
        done |=> cause_q);

    // R6: a zero write with no completion pending clears the flag
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && sel_cause && bus_wdata == '0 && !done) |=> !cause_q);

    // R7: receive register captures the shifter word at completion
    a_r7_rx_capture: assert property (@(posedge clk) disable iff (rst)
        done |=> (rx_q == $past(rx_word)));

endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             run,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);

    logic [HALF_W-1:0] half_q;
    logic [HALF_W-1:0] cnt_q;

    always_comb tick = run && (cnt_q == half_q - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_W'(2);
            cnt_q  <= '0;
        end else if (go) begin
            half_q <= eff_half(presc);
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + HALF_W'(1);
        end
    end

    // R4/R5: half period is at least two cycles, so ticks never touch
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4: counter stays inside the latched half period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < half_q));

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                wide_in,
    input  logic [WORD_MAX-1:0] tx_word,
    input  logic                tick,
    input  logic                miso,
    output logic                busy,
    output logic                sclk,
    output logic                mosi,
    output logic                done,
    output logic [WORD_MAX-1:0] rx_word
);

    localparam int PAD = WORD_MAX - WORD_MIN;

    logic                wide_q;
    logic [WORD_MAX-1:0] sh_tx;
    logic [WORD_MAX-1:0] sh_rx;
    logic [CNT_W-1:0]    bitcnt;
    logic                last;

    always_comb begin
        last    = (bitcnt == (wide_q ? CNT_W'(WORD_MAX-1) : CNT_W'(WORD_MIN-1)));
        done    = busy && tick && sclk && last;
        mosi    = busy && sh_tx[WORD_MAX-1];
        rx_word = wide_q ? sh_rx : {{PAD{1'b0}}, sh_rx[WORD_MIN-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sclk   <= 1'b0;
            wide_q <= 1'b0;
            sh_tx  <= '0;
            sh_rx  <= '0;
            bitcnt <= '0;
        end else if (go) begin
            busy   <= 1'b1;
            sclk   <= 1'b0;
            wide_q <= wide_in;
            sh_tx  <= wide_in ? tx_word : {tx_word[WORD_MIN-1:0], {PAD{1'b0}}};
            sh_rx  <= '0;
            bitcnt <= '0;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk  <= 1'b1;
                sh_rx <= {sh_rx[WORD_MAX-2:0], miso};
            end else begin
                sclk   <= 1'b0;
                sh_tx  <= {sh_tx[WORD_MAX-2:0], 1'b0};
                bitcnt <= bitcnt + CNT_W'(1);
                if (last)
                    busy <= 1'b0;
            end
        end
    end

    // R8: clock and data rest low between words
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && !mosi));

    // R8: MOSI only moves when the clock falls or a word starts
    a_r8_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && !go && !$past(go) && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

    // R9: without a tick, bit progress holds while busy
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(bitcnt));

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_csn
);

    logic                cs_on;
    cfg_t                cfg;
    logic                tx_wr;
    logic [WORD_MAX-1:0] tx_word;
    logic                go;
    logic                busy;
    logic                tick;
    logic                done;
    logic [WORD_MAX-1:0] rx_word;

    always_comb begin
        go      = tx_wr && !busy;
        spi_csn = !cs_on;
    end

    spim_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rx_word   (rx_word),
        .cs_on     (cs_on),
        .cfg       (cfg),
        .tx_wr     (tx_wr),
        .tx_word   (tx_word)
    );

    spim_clkdiv u_div (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .run   (busy),
        .presc (cfg.presc),
        .tick  (tick)
    );

    spim_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .wide_in (cfg.wide),
        .tx_word (tx_word),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (done),
        .rx_word (rx_word)
    );

    // R2: a control write sets the chip select on the next cycle
    a_r2_cs_follows: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == ADDR_W'(OFF_CTRL)) |=> (spi_csn == !$past(bus_wdata[0])));

    // R9: a transmit write during a transfer keeps the transfer running
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && busy && !done) |=> busy);

endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          spi_sclk, spi_mosi, spi_miso, spi_csn;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // slave model
    logic [15:0] slv_word = '0;
    logic [15:0] cap = '0;
    int          fall_cnt = 0;
    int          fall_base = 0;

    always #4 clk = ~clk;

    spim_ctrl #(.ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_csn   (spi_csn)
    );

    always @(posedge spi_sclk) cap <= {cap[14:0], spi_mosi};
    always @(negedge spi_sclk) fall_cnt <= fall_cnt + 1;
    assign spi_miso = ((fall_cnt - fall_base) < 16) ? slv_word[15 - (fall_cnt - fall_base)] : 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end just after a falling clock edge
    task automatic bus_write(input int addr, input logic [31:0] data);
        bus_en = 1; bus_we = 1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_en = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic bus_read(input int addr, output logic [31:0] data);
        bus_en = 1; bus_we = 0; bus_addr = AW'(addr);
        #1 data = bus_rdata;
        bus_en = 0;
        @(negedge clk);
    endtask

    // one word: returns cycles from accepting edge to cause, and rx value
    task automatic xfer(input logic [31:0] cfg, input logic [15:0] txw, input logic [15:0] sw,
                        input bit poke, output int cyc, output logic [31:0] rx);
        bit wide;
        wide = cfg[5];
        bus_write('h04, cfg);
        bus_write('h10, 32'h0);
        slv_word  = wide ? sw : {sw[7:0], 8'h00};
        fall_base = fall_cnt;
        bus_write('h08, {16'hFFFF, txw});
        cyc = 0;
        if (poke) begin
            bus_write('h08, {16'h0, ~txw});
            cyc = 1;
        end
        bus_en = 1; bus_we = 0; bus_addr = AW'('h10);
        forever begin
            #1;
            if (bus_rdata != 0 || cyc > 5000) break;
            @(negedge clk);
            cyc++;
        end
        bus_en = 0;
        @(negedge clk);
        bus_read('h0C, rx);
    endtask

    task automatic run_word(input string tag, input logic [31:0] cfg, input int half,
                            input logic [15:0] txw, input logic [15:0] sw, input bit poke);
        int n, cyc, expc;
        logic [31:0] rx, cz, exp_rx;
        logic [15:0] got, want;
        n = cfg[5] ? 16 : 8;
        expc = 2 * n * half;
        xfer(cfg, txw, sw, poke, cyc, rx);
        check(cyc == expc, {tag, " R4 cycles to cause"}, cyc, expc);
        got  = (n == 16) ? cap : {8'h00, cap[7:0]};
        want = (n == 16) ? txw : {8'h00, txw[7:0]};
        check(got == want, {tag, " R8 MSB-first MOSI word"}, got, want);
        exp_rx = (n == 16) ? {16'h0, sw} : {24'h0, sw[7:0]};
        check(rx == exp_rx, {tag, " R7 R3 receive word"}, rx, exp_rx);
        check(!spi_sclk && !spi_mosi, {tag, " R8 idle low after word"}, {spi_sclk, spi_mosi}, 0);
        bus_write('h10, 32'h5);
        bus_read('h10, cz);
        check(cz == 1, {tag, " R6 nonzero write keeps cause"}, cz, 1);
        bus_write('h10, 32'h0);
        bus_read('h10, cz);
        check(cz == 0, {tag, " R6 zero write clears cause"}, cz, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(spi_csn == 1, "R2 reset csn high", spi_csn, 1);
        check(!spi_sclk && !spi_mosi, "R8 reset idle low", {spi_sclk, spi_mosi}, 0);
        bus_read('h00, v); check(v == 0, "R1 reset ctrl", v, 0);
        bus_read('h04, v); check(v == 0, "R1 reset cfg", v, 0);
        bus_read('h10, v); check(v == 0, "R6 reset cause", v, 0);
        bus_read('h0C, v); check(v == 0, "R7 reset rx", v, 0);
    endtask

    task automatic t_cs;
        logic [31:0] v;
        bus_write('h00, 32'h1);
        check(spi_csn == 0, "R2 csn asserted", spi_csn, 0);
        bus_read('h00, v); check(v == 1, "R2 ctrl readback", v, 1);
        bus_write('h00, 32'h0);
        check(spi_csn == 1, "R2 csn released", spi_csn, 1);
    endtask

    task automatic t_map;
        logic [31:0] v;
        bus_write('h08, 32'h0);
        repeat (40) @(negedge clk);
        bus_write('h10, 32'h0);
        bus_read('h08, v); check(v == 0, "R1 tx reads zero", v, 0);
        bus_read('h14, v); check(v == 0, "R1 unmapped reads zero", v, 0);
        bus_write('h04, 32'hFFFF_FFFF);
        bus_read('h04, v); check(v == 32'h403F, "R10 cfg readback mask", v, 32'h403F);
    endtask

    task automatic t_byte_fast;  run_word("div4 byte",  32'h12, 2,  16'hA5C3, 16'h003C, 0); endtask
    task automatic t_word_div6;  run_word("div6 word",  32'h33, 3,  16'hB29E, 16'h71D4, 0); endtask
    task automatic t_slow30;     run_word("div30 byte", 32'h1F, 15, 16'h0081, 16'h00E7, 0); endtask
    task automatic t_bad_nomark; run_word("R5 no marker", 32'h0F, 2, 16'h5A, 16'h96, 0); endtask
    task automatic t_bad_half1;  run_word("R5 half one", 32'h31, 2, 16'hF00D, 16'h1234, 0); endtask
    task automatic t_busy;       run_word("R9 busy write", 32'h34, 4, 16'hC0DE, 16'h8001, 1); endtask
    task automatic t_tweak;
        logic [31:0] v;
        run_word("R10 tweak set", 32'h4033, 3, 16'h6B2F, 16'hFACE, 0);
        bus_read('h04, v); check(v == 32'h4033, "R10 tweak readback", v, 32'h4033);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_cs;
        t_map;
        t_byte_fast;
        t_word_div6;
        t_slow30;
        t_bad_nomark;
        t_bad_half1;
        t_busy;
        t_tweak;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule